// File: doc/BRIEF.md
# Successive-Approximation Sequencer with Bus-Aware Decision Deferral

This block sequences one successive-approximation conversion from the converter's input clock. An asynchronous, active-low start pulse is brought into the clock domain and answered with an active-low busy handshake. When the pulse ends, the block runs twelve binary-search trials and then one extra trial that checks for an over-range input. Each trial lasts four clocks. One more cycle writes the 13-bit result into a downstream FIFO, together with a done pulse.

A comparator decision that would coincide with host bus traffic is unsafe. If chip select and a read or write strobe are active at a rising edge where a decision is due, the decision is held back by one clock. The same test is made at every following edge, so heavy traffic can push a decision back several times. Each postponement makes the conversion exactly one clock longer. The analog comparator and the trial DAC sit outside the block: the block drives the trial code and reads back a single comparator bit.

Top module: `sarDeferSeq`

## Requirements
- R1: After reset, busyN is 1, fifoPush and convDone are 0, and dacCode is 0.
- R2: In the idle state, busyN goes to 0 at the second rising edge, counting the first edge that samples convStN low as the first.
- R3: busyN returns to 1 at the second rising edge, counting the first edge that samples convStN high as the first. From that edge, dacCode reads 100000000000 (MSB trial).
- R4: With no bus traffic, the MSB decision is taken at the fourth rising edge, counting the first high-sampling edge of convStN as the first. Later decisions follow every four clocks. fifoPush is high in the cycle after the 52nd such edge.
- R5: Each data trial for bit k drives dacCode with the decided higher bits, bit k set and the lower bits 0. Bit k is kept when cmpIn is 1 at its decision edge, so fifoData[11:0] equals the input value, clipped at 4095, for the bench's comparator (cmpIn = input >= dacCode).
- R6: During the 13th trial dacCode is all ones. fifoData[12] is the cmpIn value taken at that decision.
- R7: A rising edge at which a decision is due is skipped if csN is 0 and rdN or wrN is 0 at that edge. The decision is retried at the next edge, and each skip adds exactly one clock to the conversion.
- R8: Bus activity at edges where no decision is due has no effect on conversion length or result. The same holds for any edge where csN is 1.
- R9: Seventeen consecutive skipped decision edges lengthen the conversion by exactly 17 clocks.
- R10: convDone is high in exactly the cycle where fifoPush is high. Both last one cycle.
- R11: A start pulse arriving while a conversion is running is ignored. busyN stays 1, the timing is unchanged, and no new conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convStN | input | 1 | Asynchronous active-low start pulse; conversion begins on its release |
| csN | input | 1 | Host chip select, active low |
| rdN | input | 1 | Host read strobe, active low |
| wrN | input | 1 | Host write strobe, active low |
| cmpIn | input | 1 | Comparator result: 1 when the input is at or above dacCode |
| busyN | output | 1 | Active-low busy handshake for the start pulse |
| dacCode | output | 12 | Trial code for the external DAC |
| fifoPush | output | 1 | Write strobe for the result FIFO |
| fifoData | output | 13 | Over-range flag (bit 12) and the 12-bit result |
| convDone | output | 1 | One-cycle end-of-conversion pulse |

## Verification
Conversions are run with input values at zero, mid-scale, alternating-bit codes, exactly full scale and beyond full scale. This separates errors in the kept-bit decisions from errors in the over-range flag. Bus traffic is placed in four ways: on the first decision edge, on edges between decisions, across a decision edge, and on the last decision edge. Both read and write strobes are used, as is a read with chip select inactive. Together these separate real deferral from false deferral and show that slips add up one clock at a time, up to the 17-clock worst case. A start pulse in the middle of a trial checks that a conversion in progress cannot be restarted.

// File: rtl/sarDeferSeqPkg.sv
package sarDeferSeqPkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_TRIAL = 2'd2,
    ST_WRITE = 2'd3
  } seqStateT;

  typedef struct packed {
    logic clear;
    logic decide;
    logic inTrial;
  } seqStrobeT;
endpackage

// File: rtl/sarDeferSeqCtrl.sv
module sarDeferSeqCtrl
  import sarDeferSeqPkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int TRIAL_CLKS = 4,
  parameter int IDX_W      = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convStN,
  input  logic             csN,
  input  logic             rdN,
  input  logic             wrN,
  output logic             busyN,
  output logic             fifoPush,
  output logic             convDone,
  output seqStrobeT        strobe,
  output logic [IDX_W-1:0] trialIdx
);
  localparam int CNT_W = (TRIAL_CLKS > 2) ? $clog2(TRIAL_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(TRIAL_CLKS - 1);
  localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(TRIAL_CLKS - 2);
  localparam logic [IDX_W-1:0] IDX_OOR   = IDX_W'(DATA_W);

  seqStateT         state;
  logic [CNT_W-1:0] phaseCnt;
  logic             syncA, syncB;
  logic             startFall, startRise, busHit, decisionDue;

  // Two-stage synchronizer; edges seen between the stages
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= convStN;
      syncB <= syncA;
    end
  end

  assign startFall   = syncB & ~syncA;
  assign startRise   = ~syncB & syncA;
  assign busHit      = ~csN & (~rdN | ~wrN);
  assign decisionDue = (state == ST_TRIAL) && (phaseCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      trialIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE:  if (startFall) state <= ST_START;
        ST_START: if (startRise) begin
          state    <= ST_TRIAL;
          phaseCnt <= CNT_FIRST;
          trialIdx <= '0;
        end
        ST_TRIAL: begin
          if (phaseCnt != CNT_LAST) begin
            phaseCnt <= phaseCnt + 1'b1;
          end else if (!busHit) begin
            phaseCnt <= '0;
            if (trialIdx == IDX_OOR) state <= ST_WRITE;
            else trialIdx <= trialIdx + 1'b1;
          end
        end
        ST_WRITE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.clear   = (state == ST_START) && startRise;
  assign strobe.decide  = decisionDue && !busHit;
  assign strobe.inTrial = (state == ST_TRIAL);
  assign busyN          = (state != ST_START);
  assign fifoPush       = (state == ST_WRITE);
  assign convDone       = (state == ST_WRITE);
endmodule

// File: rtl/sarDeferSeqData.sv
module sarDeferSeqData
  import sarDeferSeqPkg::*;
#(
  parameter int DATA_W = 12,
  parameter int IDX_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobe,
  input  logic [IDX_W-1:0]  trialIdx,
  input  logic              cmpIn,
  output logic [DATA_W-1:0] dacCode,
  output logic [DATA_W:0]   fifoData
);
  logic [DATA_W-1:0] result;
  logic              oorBit;
  logic [DATA_W-1:0] trialMask;

  always_comb begin
    trialMask = '0;
    for (int b = 0; b < DATA_W; b++)
      if (int'(trialIdx) == DATA_W - 1 - b) trialMask[b] = 1'b1;
  end

  always_comb begin
    if (!strobe.inTrial)              dacCode = result;
    else if (int'(trialIdx) < DATA_W) dacCode = result | trialMask;
    else                              dacCode = '1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      oorBit <= 1'b0;
    end else if (strobe.clear) begin
      result <= '0;
      oorBit <= 1'b0;
    end else if (strobe.decide) begin
      if (int'(trialIdx) >= DATA_W) oorBit <= cmpIn;
      for (int b = 0; b < DATA_W; b++)
        if (trialMask[b]) result[b] <= cmpIn;
    end
  end

  assign fifoData = {oorBit, result};
endmodule

// File: rtl/sarDeferSeq.sv
module sarDeferSeq
  import sarDeferSeqPkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int TRIAL_CLKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convStN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              cmpIn,
  output logic              busyN,
  output logic [DATA_W-1:0] dacCode,
  output logic              fifoPush,
  output logic [DATA_W:0]   fifoData,
  output logic              convDone
);
  localparam int IDX_W = $clog2(DATA_W + 1);

  seqStrobeT        strobe;
  logic [IDX_W-1:0] trialIdx;

  sarDeferSeqCtrl #(.DATA_W(DATA_W), .TRIAL_CLKS(TRIAL_CLKS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .convStN(convStN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .busyN(busyN), .fifoPush(fifoPush), .convDone(convDone),
    .strobe(strobe), .trialIdx(trialIdx)
  );

  sarDeferSeqData #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .trialIdx(trialIdx),
    .cmpIn(cmpIn), .dacCode(dacCode), .fifoData(fifoData)
  );
endmodule

// File: rtl/sarDeferSeqChecker.sv
module sarDeferSeqChecker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rdN,
  input logic              wrN,
  input logic              busyN,
  input logic [DATA_W-1:0] dacCode,
  input logic              fifoPush,
  input logic              convDone
);
  localparam logic [DATA_W-1:0] MSB_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  a_r10_push_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    fifoPush |=> !fifoPush);

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone);

  a_r3_msb_on_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyN) |-> (dacCode == MSB_CODE));

  a_r7_no_decision_on_bus: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && (!rdN || !wrN) && busyN && !fifoPush) |=> $stable(dacCode));

  a_r11_no_push_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    !busyN |-> !fifoPush);
endmodule

bind sarDeferSeq sarDeferSeqChecker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
  .busyN(busyN), .dacCode(dacCode), .fifoPush(fifoPush), .convDone(convDone)
);

// File: tb/sarDeferSeq_bench.sv
module sarDeferSeq_bench;
  localparam int W = 12;
  localparam int NV = 9;
  // vin, bus first edge, bus length, kind (0 cs+rd, 1 cs+wr, 2 rd without cs), restart edge, expected slip
  localparam int VIN [NV] = '{0, 2730, 1365, 4096, 5000, 2048, 4095, 123, 8191};
  localparam int BST [NV] = '{0, 3,    3,    4,    5,    3,    3,    0,   51};
  localparam int BLEN[NV] = '{0, 1,    4,    1,    3,    5,    17,   0,   2};
  localparam int KIND[NV] = '{0, 0,    1,    0,    0,    2,    0,    0,   1};
  localparam int RST [NV] = '{0, 0,    0,    0,    0,    0,    0,    10,  0};
  localparam int SLIP[NV] = '{0, 1,    4,    0,    1,    0,    17,   0,   2};

  logic clk = 1'b0, rstN = 1'b0;
  logic convStN = 1'b1, csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [12:0] vin = '0;
  logic cmpIn, busyN, fifoPush, convDone;
  logic [W-1:0] dacCode;
  logic [W:0] fifoData;
  int nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;
  assign cmpIn = (vin >= {1'b0, dacCode});

  sarDeferSeq u_sarDeferSeq (
    .clk(clk), .rstN(rstN), .convStN(convStN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .cmpIn(cmpIn), .busyN(busyN), .dacCode(dacCode), .fifoPush(fifoPush),
    .fifoData(fifoData), .convDone(convDone)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runConv(input int v);
    int pushAt;
    int expData;
    logic busyDropped;
    pushAt = -1;
    busyDropped = 1'b0;
    vin = 13'(VIN[v]);
    expData = (VIN[v] > 4095) ? 4095 : VIN[v];
    convStN = 1'b0;
    tick();  // E0
    check(busyN == 1'b1, "R2 busy not yet low", busyN, 1);
    tick();  // E1
    check(busyN == 1'b0, "R2 busy low", busyN, 0);
    convStN = 1'b1;
    tick();  // R0
    check(busyN == 1'b0, "R3 busy still low", busyN, 0);
    tick();  // R1
    check(busyN == 1'b1, "R3 busy released", busyN, 1);
    check(dacCode == 12'h800, "R3 MSB trial code", dacCode, 12'h800);
    for (int i = 2; i < 120 && pushAt < 0; i++) begin
      if (BLEN[v] > 0 && i >= BST[v] && i < BST[v] + BLEN[v]) begin
        csN = (KIND[v] == 2);
        rdN = (KIND[v] == 1);
        wrN = (KIND[v] != 1);
      end else begin
        csN = 1'b1; rdN = 1'b1; wrN = 1'b1;
      end
      if (RST[v] > 0) convStN = !(i >= RST[v] && i < RST[v] + 3);
      tick();
      if (!busyN) busyDropped = 1'b1;
      if (fifoPush) begin
        pushAt = i;
        check(convDone == 1'b1, "R10 done with push", convDone, 1);
        check(fifoData[W-1:0] == W'(expData), "R5 result", fifoData[W-1:0], expData);
        check(fifoData[W] == (VIN[v] >= 4095), "R6 over-range flag", fifoData[W], VIN[v] >= 4095);
      end
    end
    csN = 1'b1; rdN = 1'b1; wrN = 1'b1; convStN = 1'b1;
    if (SLIP[v] == 17)
      check(pushAt == 51 + SLIP[v], "R9 seventeen slips", pushAt, 51 + SLIP[v]);
    else if (SLIP[v] > 0)
      check(pushAt == 51 + SLIP[v], "R7 deferral length", pushAt, 51 + SLIP[v]);
    else
      check(pushAt == 51, "R4 R8 nominal length", pushAt, 51);
    if (RST[v] > 0)
      check(busyDropped == 1'b0, "R11 restart ignored", busyDropped, 0);
    tick();
    check(fifoPush == 1'b0 && convDone == 1'b0, "R10 single cycle", fifoPush, 0);
    tick();
    tick();
    check(busyN == 1'b1 && fifoPush == 1'b0, "R11 no follow-on conversion", busyN, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busyN == 1'b1, "R1 busy reset", busyN, 1);
    check(fifoPush == 1'b0 && convDone == 1'b0, "R1 push reset", fifoPush, 0);
    check(dacCode == '0, "R1 code reset", dacCode, 0);
    rstN = 1'b1;
    tick();
    tick();
    for (int v = 0; v < NV; v++) runConv(v);
    // directed: restart pulse right after completion starts a fresh one normally
    runConv(0);
    // directed: reset in the middle of a conversion returns to idle state
    convStN = 1'b0; tick(); tick(); convStN = 1'b1;
    tick(); tick(); tick(); tick();
    rstN = 1'b0;
    @(negedge clk);
    check(busyN == 1'b1 && dacCode == '0, "R1 mid-run reset", dacCode, 0);
    rstN = 1'b1;
    tick();
    runConv(1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule